// File: doc/BRIEF.md
# Signed-Digit Modular Adder/Subtractor

This block adds or subtracts two operands held in radix-2 signed-digit form and folds the result back toward the signed range of a modulus. Each digit is +1, 0 or -1, so the sum is formed without a carry that runs across the word. Subtraction flips the sign of every digit of the second operand instead of forming a two's complement. The modulus arrives as a plain binary word and is widened into signed-digit form by pairing each bit with a zero bit.

A single full-width digit adder is used twice per operation. A pulse on `start` computes A plus or minus B into an internal accumulator. In the following cycle the adder adds or subtracts the captured modulus once, chosen by the sign of the accumulator's leading non-zero digit. The registered result, N+2 digits wide, is flagged valid for one cycle and then held until the next result. A binary view of the result, the positive-digit vector minus the negative-digit vector, is driven alongside it so it can be checked.

Top module: `rsd_mod_addsub`

## Requirements
- R1: Digits use the two-bit code 0 = 2'b00, +1 = 2'b10, -1 = 2'b01, with digit i at bits [2i+1:2i]. The result never contains the code 2'b11.
- R2: A digit coded 2'b11 on either operand is read as 0.
- R3: With subSel = 0, let raw = value(A) + value(B). The result value is raw - M if raw > 0, raw + M if raw < 0, and 0 if raw = 0. M is the binary modulus.
- R4: With subSel = 1 the same rule applies, with raw = value(A) - value(B).
- R5: modBin is an unsigned binary word. Bit i becomes signed digit i with code {modBin[i], 1'b0}.
- R6: Suppose start is seen high at a clock edge while the block is idle. Then resValid is low after that edge, high for exactly one cycle after the next edge, and low again after the edge that follows.
- R7: A start seen during the correction cycle is ignored. It produces no extra result and does not alter the one in flight.
- R8: resRsd and resBin keep their values between valid pulses.
- R9: resBin equals the sum over all digits of the digit value times 2^i of resRsd.
- R10: After reset, resValid is 0 and resRsd and resBin are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| subSel | input | 1 | 0 = A + B, 1 = A - B |
| opA | input | 2*N | First operand, N signed digits |
| opB | input | 2*N | Second operand, N signed digits |
| modBin | input | N | Modulus, unsigned binary |
| resValid | output | 1 | One-cycle flag for a new result |
| resRsd | output | 2*(N+2) | Result, N+2 signed digits |
| resBin | output | N+3 | Result as a signed two's-complement number |

## Verification
The arithmetic is exercised in several ways. Operands of all +1 digits and all -1 digits drive transfers through every position and expose any loss of a digit-to-digit transfer. Zero and exactly cancelling operands take the branch where no correction is applied. Random mixed-sign operands under both add and subtract separate the two correction directions and catch a wrong negation. Operands that contain the unused 2'b11 code, a back-to-back start, and a zero modulus check that illegal digits are read as 0, that a busy block ignores start, and that the correction uses the captured modulus.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic {ST_IDLE, ST_REDUCE} rsdStateT;

  typedef struct packed {
    logic loadSum;
    logic loadRes;
  } rsdStrobeT;

  // signed value of one digit code; the unused code reads as zero
  function automatic logic signed [2:0] rsdVal(input logic [1:0] code);
    case (code)
      2'b10:   return 3'sd1;
      2'b01:   return -3'sd1;
      default: return 3'sd0;
    endcase
  endfunction

  function automatic logic [1:0] rsdEnc(input logic signed [2:0] v);
    case (v)
      3'b001:  return 2'b10;
      3'b111:  return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] rsdClean(input logic [1:0] code);
    return (code == 2'b11) ? 2'b00 : code;
  endfunction

  function automatic logic [1:0] rsdNeg(input logic [1:0] code);
    return {code[0], code[1]};
  endfunction

endpackage

// File: rtl/rsd_from_bin.sv
module rsd_from_bin #(
  parameter int N = 8
) (
  input  logic [N-1:0]   binIn,
  output logic [2*N-1:0] rsdOut
);
  for (genvar g = 0; g < N; g++) begin : g_dig
    assign rsdOut[2*g +: 2] = {binIn[g], 1'b0};
  end
endmodule

// File: rtl/rsd_to_bin.sv
module rsd_to_bin #(
  parameter int W = 10
) (
  input  logic [2*W-1:0]    rsdIn,
  output logic signed [W:0] valOut
);
  logic [W-1:0] posVec;
  logic [W-1:0] negVec;

  for (genvar g = 0; g < W; g++) begin : g_split
    assign posVec[g] = rsdIn[2*g+1];
    assign negVec[g] = rsdIn[2*g];
  end

  assign valOut = $signed({1'b0, posVec}) - $signed({1'b0, negVec});
endmodule

// File: rtl/rsd_adder.sv
module rsd_adder
  import rsd_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [2*W-1:0] xIn,
  input  logic [2*W-1:0] yIn,
  output logic [2*W-1:0] sumOut
);
  logic signed [2:0] pSum   [W];
  logic              lowNn  [W];
  logic signed [2:0] tIn    [W];
  logic signed [2:0] wKeep  [W];

  // Transfer into digit i depends only on positions i-1 and i-2,
  // so no chain runs across the word.
  always_comb begin
    logic signed [2:0] tv;
    logic signed [2:0] wv;
    for (int i = 0; i < W; i++) begin
      pSum[i] = rsdVal(xIn[2*i +: 2]) + rsdVal(yIn[2*i +: 2]);
    end
    lowNn[0] = 1'b1;
    for (int i = 1; i < W; i++) begin
      lowNn[i] = !pSum[i-1][2];
    end
    tIn[0] = 3'sd0;
    for (int i = 0; i < W; i++) begin
      case (pSum[i])
        3'b010: begin tv = 3'sd1;  wv = 3'sd0; end
        3'b110: begin tv = -3'sd1; wv = 3'sd0; end
        3'b001: begin
          if (lowNn[i]) begin tv = 3'sd1; wv = -3'sd1; end
          else          begin tv = 3'sd0; wv = 3'sd1;  end
        end
        3'b111: begin
          if (lowNn[i]) begin tv = 3'sd0;  wv = -3'sd1; end
          else          begin tv = -3'sd1; wv = 3'sd1;  end
        end
        default: begin tv = 3'sd0; wv = 3'sd0; end
      endcase
      wKeep[i] = wv;
      if (i < W-1) tIn[i+1] = tv;
    end
    for (int i = 0; i < W; i++) begin
      sumOut[2*i +: 2] = rsdEnc(wKeep[i] + tIn[i]);
    end
  end
endmodule

// File: rtl/rsd_mod_ctrl.sv
module rsd_mod_ctrl
  import rsd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output rsdStrobeT strobes,
  output logic      resValid
);
  rsdStateT state;

  always_comb begin
    strobes.loadSum = (state == ST_IDLE) && start;
    strobes.loadRes = (state == ST_REDUCE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      resValid <= 1'b0;
    end else begin
      resValid <= strobes.loadRes;
      case (state)
        ST_IDLE:   if (start) state <= ST_REDUCE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
  // R6
  sum_then_reduce_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSum |=> strobes.loadRes);
  // R7
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRes |=> !strobes.loadRes);
  // R6
  valid_after_reduce_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRes |=> resValid);
endmodule

// File: rtl/rsd_mod_datapath.sv
module rsd_mod_datapath
  import rsd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  rsdStrobeT        strobes,
  input  logic             subSel,
  input  logic [2*N-1:0]   opA,
  input  logic [2*N-1:0]   opB,
  input  logic [N-1:0]     modBin,
  output logic [2*(N+2)-1:0] resRsd
);
  localparam int W  = N + 2;
  localparam int WB = 2 * W;

  logic [2*N-1:0] aClean, bSigned, modRsd;
  logic [WB-1:0]  aExt, bExt, modExt, corr;
  logic [WB-1:0]  xSel, ySel, sumW;
  logic [WB-1:0]  accReg, resReg;
  logic [N-1:0]   modReg;
  logic [1:0]     accLead;
  logic [W-1:0]   resBad;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      aClean[2*i +: 2]  = rsdClean(opA[2*i +: 2]);
      bSigned[2*i +: 2] = subSel ? rsdNeg(rsdClean(opB[2*i +: 2]))
                                 : rsdClean(opB[2*i +: 2]);
    end
  end

  rsd_from_bin #(.N(N)) modConv_i (.binIn(modReg), .rsdOut(modRsd));

  assign aExt   = {4'b0000, aClean};
  assign bExt   = {4'b0000, bSigned};
  assign modExt = {4'b0000, modRsd};

  // sign of the accumulator = sign of its leading non-zero digit
  always_comb begin
    accLead = 2'b00;
    for (int i = 0; i < W; i++) begin
      if (accReg[2*i +: 2] != 2'b00) accLead = accReg[2*i +: 2];
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      case (accLead)
        2'b10:   corr[2*i +: 2] = rsdNeg(modExt[2*i +: 2]);
        2'b01:   corr[2*i +: 2] = modExt[2*i +: 2];
        default: corr[2*i +: 2] = 2'b00;
      endcase
    end
  end

  assign xSel = strobes.loadRes ? accReg : aExt;
  assign ySel = strobes.loadRes ? corr   : bExt;

  rsd_adder #(.W(W)) adder_i (.xIn(xSel), .yIn(ySel), .sumOut(sumW));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
      modReg <= '0;
      resReg <= '0;
    end else begin
      if (strobes.loadSum) begin
        accReg <= sumW;
        modReg <= modBin;
      end
      if (strobes.loadRes) resReg <= sumW;
    end
  end

  assign resRsd = resReg;

  for (genvar g = 0; g < W; g++) begin : g_bad
    assign resBad[g] = resReg[2*g+1] & resReg[2*g];
  end

  // R1
  res_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    resBad == '0);
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadRes |=> $stable(resReg));
endmodule

// File: rtl/rsd_mod_addsub.sv
module rsd_mod_addsub
  import rsd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 subSel,
  input  logic [2*N-1:0]       opA,
  input  logic [2*N-1:0]       opB,
  input  logic [N-1:0]         modBin,
  output logic                 resValid,
  output logic [2*(N+2)-1:0]   resRsd,
  output logic signed [N+2:0]  resBin
);
  localparam int W = N + 2;

  rsdStrobeT strobes;

  rsd_mod_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .resValid(resValid)
  );

  rsd_mod_datapath #(.N(N)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .subSel(subSel),
    .opA(opA), .opB(opB), .modBin(modBin), .resRsd(resRsd)
  );

  rsd_to_bin #(.W(W)) toBin_i (.rsdIn(resRsd), .valOut(resBin));
endmodule

// File: tb/rsd_mod_addsub_tb_top.sv
module rsd_mod_addsub_tb_top;
  localparam int N = 8;
  localparam int W = N + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic subSel = 1'b0;
  logic [2*N-1:0] opA = '0;
  logic [2*N-1:0] opB = '0;
  logic [N-1:0]   modBin = '0;
  logic           resValid;
  logic [2*W-1:0] resRsd;
  logic signed [W:0] resBin;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int expQ[$];
  string tagQ[$];

  rsd_mod_addsub #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .subSel(subSel),
    .opA(opA), .opB(opB), .modBin(modBin),
    .resValid(resValid), .resRsd(resRsd), .resBin(resBin)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: code 2'b11 reads as 0
  function automatic int opValue(input logic [2*N-1:0] v);
    int s = 0;
    for (int i = 0; i < N; i++) begin
      if (v[2*i +: 2] == 2'b10) s += (1 << i);
      else if (v[2*i +: 2] == 2'b01) s -= (1 << i);
    end
    return s;
  endfunction

  function automatic int resValue(input logic [2*W-1:0] v);
    int s = 0;
    for (int i = 0; i < W; i++) begin
      if (v[2*i +: 2] == 2'b10) s += (1 << i);
      else if (v[2*i +: 2] == 2'b01) s -= (1 << i);
    end
    return s;
  endfunction

  function automatic int illegalCount(input logic [2*W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) if (v[2*i +: 2] == 2'b11) c++;
    return c;
  endfunction

  function automatic int refResult(input int a, input int b, input bit sub, input int m);
    int raw = sub ? a - b : a + b;
    if (raw > 0) return raw - m;
    if (raw < 0) return raw + m;
    return 0;
  endfunction

  function automatic logic [2*N-1:0] randOp();
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) begin
      case ($urandom % 3)
        0: v[2*i +: 2] = 2'b00;
        1: v[2*i +: 2] = 2'b10;
        default: v[2*i +: 2] = 2'b01;
      endcase
    end
    return v;
  endfunction

  // monitor: pops the scoreboard on every valid pulse
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected result", int'(resBin), 0);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(int'(resBin) == e, t, int'(resBin), e);
        check(resValue(resRsd) == int'(resBin), "R9 digits vs binary", resValue(resRsd), int'(resBin));
        check(illegalCount(resRsd) == 0, "R1 no 2'b11 digit", illegalCount(resRsd), 0);
      end
    end
  end

  task automatic runOp(input logic [2*N-1:0] a, input logic [2*N-1:0] b,
                       input bit sub, input logic [N-1:0] m, input string tag);
    logic [2*W-1:0] hold;
    @(negedge clk);
    opA = a; opB = b; subSel = sub; modBin = m; start = 1'b1;
    expQ.push_back(refResult(opValue(a), opValue(b), sub, int'(m)));
    tagQ.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    opA = randOp(); opB = randOp(); modBin = N'($urandom);
    check(resValid == 1'b0, "R6 low after first edge", int'(resValid), 0);
    @(negedge clk);
    check(resValid == 1'b1, "R6 high after second edge", int'(resValid), 1);
    hold = resRsd;
    @(negedge clk);
    check(resValid == 1'b0, "R6 single-cycle valid", int'(resValid), 0);
    check(resRsd == hold, "R8 result held", resValue(resRsd), resValue(hold));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2*N-1:0] allPos, allNeg, allBad, oneLsb;
    for (int i = 0; i < N; i++) begin
      allPos[2*i +: 2] = 2'b10;
      allNeg[2*i +: 2] = 2'b01;
      allBad[2*i +: 2] = 2'b11;
    end
    oneLsb = {{(2*N-2){1'b0}}, 2'b10};

    repeat (3) @(negedge clk);
    // R10 reset state
    check(resValid == 1'b0, "R10 valid in reset", int'(resValid), 0);
    check(resRsd == '0, "R10 digits in reset", resValue(resRsd), 0);
    check(resBin == '0, "R10 binary in reset", int'(resBin), 0);
    rstN = 1'b1;

    runOp('0, '0, 1'b0, 8'd77, "R3 zero sum");
    runOp(allPos, oneLsb, 1'b0, 8'd200, "R3 full transfer run");
    runOp(allNeg, allNeg, 1'b0, 8'd255, "R3 negative sum");
    runOp(allPos, allPos, 1'b1, 8'd13, "R4 exact cancel");
    runOp(allNeg, allPos, 1'b1, 8'd129, "R4 negative difference");
    runOp(oneLsb, allNeg, 1'b1, 8'd1, "R4 positive difference");
    // R5: modulus bit pattern with sparse ones
    runOp(allPos, '0, 1'b0, 8'b1000_0001, "R5 modulus bits 7 and 0");
    runOp(allNeg, '0, 1'b0, 8'b0101_0000, "R5 modulus bits 6 and 4");
    runOp(allPos, allPos, 1'b0, 8'd0, "R3 zero modulus");
    // R2: illegal codes on inputs read as 0
    runOp(allBad, oneLsb, 1'b0, 8'd50, "R2 opA all 2'b11");
    runOp(allPos, allBad, 1'b1, 8'd100, "R2 opB all 2'b11");
    runOp({allBad[2*N-1:N], allPos[N-1:0]}, {allNeg[2*N-1:N], allBad[N-1:0]},
          1'b0, 8'd40, "R2 mixed 2'b11");

    for (int k = 0; k < 40; k++) begin
      bit s;
      s = k[0];
      runOp(randOp(), randOp(), s, N'($urandom_range(255, 1)), s ? "R4 random" : "R3 random");
    end

    // R7: start held during the correction cycle is ignored
    @(negedge clk);
    opA = allPos; opB = oneLsb; subSel = 1'b0; modBin = 8'd90; start = 1'b1;
    expQ.push_back(refResult(opValue(allPos), opValue(oneLsb), 1'b0, 90));
    tagQ.push_back("R7 first start kept");
    @(negedge clk);
    opA = allNeg; opB = allNeg; modBin = 8'd3;
    @(negedge clk);
    start = 1'b0;
    check(resValid == 1'b1, "R7 valid for first start", int'(resValid), 1);
    @(negedge clk);
    check(resValid == 1'b0, "R7 no second result", int'(resValid), 0);
    repeat (3) @(negedge clk);
    check(resValid == 1'b0, "R7 still idle", int'(resValid), 0);
    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule